// File: doc/BRIEF.md
# Per-Channel Copy Engine Register File

This block holds the software-visible registers of a multi-channel memory copy engine. Every channel has the same register set: two ring base addresses (low and high words), two ring depths, a submission tail, a completion head, two control words, a state readback and an interrupt status/mask pair. The sets repeat every 0x100 bytes of address space. A single global word selects endpoint or root-complex operation. Access is through a plain 32-bit bus with a write strobe. Reads are combinational from the address.

Toward each channel controller the block drives a queue-enable level and a pause level. It also drives two single-cycle strobes: a queue-reset strobe and a doorbell that fires on every submission tail write. The controller returns a 4-bit state and a 13-bit vector of event pulses. The events latch into the status word, and each channel raises its own interrupt line while any latched bit is unmasked.

Top module: `dma_chan_regfile`

## Requirements
- R1: Channel n's set starts at byte address n*0x100. Within a set, the base words at 0x00, 0x04, 0x10 and 0x14 store and read back all 32 bits. The depths at 0x08 and 0x18, the tail at 0x0C and the head at 0x1C keep the low 16 bits and read with zero upper bits.
- R2: Control word 0 at 0x20 keeps bit 0 (queue enable, drives `q_en_o[n]`) and bit 4 (pause, drives `q_pause_o[n]`). Its other bits read zero.
- R3: Writing 1 to bit 0 of control word 1 at 0x24 raises `q_reset_o[n]` for exactly one cycle, starting the cycle after the write. Bit 0 of 0x24 reads 1 during that cycle and 0 after it. The stored tail and head read zero once the strobe ends.
- R4: A write to offset 0x0C raises `doorbell_o[n]` for one cycle, starting the cycle after the write. No other channel's doorbell rises.
- R5: Offset 0x30 returns the channel's `state_i` nibble in bits 3:0. Writes to it have no effect.
- R6: Interrupt status at 0x40 is 13 bits. An event pulse sets the matching bit. Writing 1 to a bit clears it. An event arriving in the same cycle as a clear leaves the bit set.
- R7: Interrupt mask at 0x44 is 13 bits and resets to all ones. `irq_o[n]` is high exactly while some status bit is set and its mask bit is zero.
- R8: The word at 0x217C holds bit 0, which drives `mode_o` (1 = root complex, 0 = endpoint). It resets to 0.
- R9: Reads of unmapped offsets, misaligned addresses and channel indices at or above the channel count return zero. Writes to them change no register.
- R10: After reset every register reads zero except the mask, all strobes are low and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 14 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| state_i | input | 120 | 4-bit state per channel, channel n in bits 4n+3:4n |
| evt_i | input | 390 | 13 event pulses per channel, channel n in bits 13n+12:13n |
| q_en_o | output | 30 | Queue enable per channel |
| q_pause_o | output | 30 | Queue pause per channel |
| q_reset_o | output | 30 | One-cycle queue reset strobe per channel |
| doorbell_o | output | 30 | One-cycle doorbell per channel |
| irq_o | output | 30 | Interrupt line per channel |
| mode_o | output | 1 | 1 = root complex, 0 = endpoint |

## Verification
A vector table writes distinctive patterns to every register kind, spread over the first, middle and last channels, and reads each back. The patterns are full-width words, all-ones words and values wider than the field. This separates correct field truncation from aliasing between channels. All-ones writes to control, gap offsets and out-of-range channels show whether unused bits and holes stay zero. Directed sequences pair an event pulse with a clearing write in the same cycle, toggle the mask around latched status, and issue a queue reset after a tail write. These sequences separate set priority, mask gating and the pointer clear from plain register storage.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int OFF_W   = 8;
  localparam int STS_W   = 13;
  localparam int STATE_W = 4;

  localparam logic [OFF_W-1:0] OFF_SQ_LO   = 8'h00;
  localparam logic [OFF_W-1:0] OFF_SQ_HI   = 8'h04;
  localparam logic [OFF_W-1:0] OFF_SQ_DEP  = 8'h08;
  localparam logic [OFF_W-1:0] OFF_SQ_TAIL = 8'h0C;
  localparam logic [OFF_W-1:0] OFF_CQ_LO   = 8'h10;
  localparam logic [OFF_W-1:0] OFF_CQ_HI   = 8'h14;
  localparam logic [OFF_W-1:0] OFF_CQ_DEP  = 8'h18;
  localparam logic [OFF_W-1:0] OFF_CQ_HEAD = 8'h1C;
  localparam logic [OFF_W-1:0] OFF_CTRL0   = 8'h20;
  localparam logic [OFF_W-1:0] OFF_CTRL1   = 8'h24;
  localparam logic [OFF_W-1:0] OFF_STATE   = 8'h30;
  localparam logic [OFF_W-1:0] OFF_INT_STS = 8'h40;
  localparam logic [OFF_W-1:0] OFF_INT_MSK = 8'h44;

  localparam int CTRL0_EN_BIT    = 0;
  localparam int CTRL0_PAUSE_BIT = 4;
  localparam int CTRL1_RST_BIT   = 0;
endpackage

// File: rtl/dma_addr_dec.sv
module dma_addr_dec #(
  parameter int ADDR_W = 14,
  parameter int N_CH   = 30,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 14'h217C,
  localparam int CH_IDX_W = ADDR_W - dma_regs_pkg::OFF_W
) (
  input  logic [ADDR_W-1:0]              addr_i,
  output logic [CH_IDX_W-1:0]            ch_idx_o,
  output logic [dma_regs_pkg::OFF_W-1:0] off_o,
  output logic                           ch_hit_o,
  output logic                           mode_hit_o
);
  logic aligned;

  assign aligned    = (addr_i[1:0] == 2'b00);
  assign ch_idx_o   = addr_i[ADDR_W-1:dma_regs_pkg::OFF_W];
  assign off_o      = addr_i[dma_regs_pkg::OFF_W-1:0];
  assign ch_hit_o   = aligned && (32'(ch_idx_o) < N_CH);
  assign mode_hit_o = (addr_i == MODE_ADDR);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [31:0]        wdata_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [STS_W-1:0]   evt_i,
  output logic [31:0]        rdata_o,
  output logic               q_en_o,
  output logic               q_pause_o,
  output logic               q_reset_o,
  output logic               doorbell_o,
  output logic               irq_o
);
  logic [31:0]      sq_lo, sq_hi, cq_lo, cq_hi;
  logic [PTR_W-1:0] sq_dep, sq_tail, cq_dep, cq_head;
  logic             en_q, pause_q, rst_q, door_q;
  logic [STS_W-1:0] sts_q, msk_q, w1c;

  assign w1c = (wr_i && off_i == OFF_INT_STS) ? wdata_i[STS_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_lo   <= '0;
      sq_hi   <= '0;
      cq_lo   <= '0;
      cq_hi   <= '0;
      sq_dep  <= '0;
      sq_tail <= '0;
      cq_dep  <= '0;
      cq_head <= '0;
      en_q    <= 1'b0;
      pause_q <= 1'b0;
      rst_q   <= 1'b0;
      door_q  <= 1'b0;
      sts_q   <= '0;
      msk_q   <= '1;
    end else begin
      door_q <= wr_i && (off_i == OFF_SQ_TAIL);
      // self-clearing: never held two cycles in a row
      rst_q  <= wr_i && (off_i == OFF_CTRL1) && wdata_i[CTRL1_RST_BIT] && !rst_q;
      if (wr_i) begin
        unique case (off_i)
          OFF_SQ_LO:   sq_lo   <= wdata_i;
          OFF_SQ_HI:   sq_hi   <= wdata_i;
          OFF_SQ_DEP:  sq_dep  <= wdata_i[PTR_W-1:0];
          OFF_SQ_TAIL: sq_tail <= wdata_i[PTR_W-1:0];
          OFF_CQ_LO:   cq_lo   <= wdata_i;
          OFF_CQ_HI:   cq_hi   <= wdata_i;
          OFF_CQ_DEP:  cq_dep  <= wdata_i[PTR_W-1:0];
          OFF_CQ_HEAD: cq_head <= wdata_i[PTR_W-1:0];
          OFF_CTRL0: begin
            en_q    <= wdata_i[CTRL0_EN_BIT];
            pause_q <= wdata_i[CTRL0_PAUSE_BIT];
          end
          OFF_INT_MSK: msk_q <= wdata_i[STS_W-1:0];
          default: ;
        endcase
      end
      // queue reset wins over a pointer write in the same cycle
      if (rst_q) begin
        sq_tail <= '0;
        cq_head <= '0;
      end
      sts_q <= (sts_q & ~w1c) | evt_i;
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_SQ_LO:   rdata_o = sq_lo;
      OFF_SQ_HI:   rdata_o = sq_hi;
      OFF_SQ_DEP:  rdata_o = 32'(sq_dep);
      OFF_SQ_TAIL: rdata_o = 32'(sq_tail);
      OFF_CQ_LO:   rdata_o = cq_lo;
      OFF_CQ_HI:   rdata_o = cq_hi;
      OFF_CQ_DEP:  rdata_o = 32'(cq_dep);
      OFF_CQ_HEAD: rdata_o = 32'(cq_head);
      OFF_CTRL0:   rdata_o = 32'({pause_q, 3'b000, en_q});
      OFF_CTRL1:   rdata_o = 32'(rst_q);
      OFF_STATE:   rdata_o = 32'(state_i);
      OFF_INT_STS: rdata_o = 32'(sts_q);
      OFF_INT_MSK: rdata_o = 32'(msk_q);
      default:     rdata_o = '0;
    endcase
  end

  assign q_en_o     = en_q;
  assign q_pause_o  = pause_q;
  assign q_reset_o  = rst_q;
  assign doorbell_o = door_q;
  assign irq_o      = |(sts_q & ~msk_q);

  p_reset_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_reset_o |=> !q_reset_o);
  p_reset_ptr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_reset_o |=> (sq_tail == '0 && cq_head == '0));
  p_doorbell_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(doorbell_o) |-> $past(wr_i && off_i == OFF_SQ_TAIL));
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));
  p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_INT_STS && evt_i == '0) |=> ((sts_q & $past(wdata_i[STS_W-1:0])) == '0));
  p_irq_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(evt_i != '0 || (wr_i && off_i == OFF_INT_MSK)));
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
  import dma_regs_pkg::*;
#(
  parameter int N_CH   = 30,
  parameter int ADDR_W = 14,
  parameter int PTR_W  = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 14'h217C,
  localparam int CH_IDX_W = ADDR_W - OFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [N_CH*STATE_W-1:0] state_i,
  input  logic [N_CH*STS_W-1:0]   evt_i,
  output logic [N_CH-1:0]         q_en_o,
  output logic [N_CH-1:0]         q_pause_o,
  output logic [N_CH-1:0]         q_reset_o,
  output logic [N_CH-1:0]         doorbell_o,
  output logic [N_CH-1:0]         irq_o,
  output logic                    mode_o
);
  logic [CH_IDX_W-1:0] ch_idx;
  logic [OFF_W-1:0]    off;
  logic                ch_hit, mode_hit, mode_q;
  logic [31:0]         chan_rdata [N_CH];

  dma_addr_dec #(
    .ADDR_W    (ADDR_W),
    .N_CH      (N_CH),
    .MODE_ADDR (MODE_ADDR)
  ) u_dec (
    .addr_i     (addr_i),
    .ch_idx_o   (ch_idx),
    .off_o      (off),
    .ch_hit_o   (ch_hit),
    .mode_hit_o (mode_hit)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic wr_sel;
    assign wr_sel = wr_en_i && ch_hit && (ch_idx == CH_IDX_W'(g));

    dma_chan_regs #(.PTR_W(PTR_W)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_sel),
      .off_i      (off),
      .wdata_i    (wdata_i),
      .state_i    (state_i[g*STATE_W +: STATE_W]),
      .evt_i      (evt_i[g*STS_W +: STS_W]),
      .rdata_o    (chan_rdata[g]),
      .q_en_o     (q_en_o[g]),
      .q_pause_o  (q_pause_o[g]),
      .q_reset_o  (q_reset_o[g]),
      .doorbell_o (doorbell_o[g]),
      .irq_o      (irq_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  mode_q <= 1'b0;
    else if (wr_en_i && mode_hit) mode_q <= wdata_i[0];
  end
  assign mode_o = mode_q;

  always_comb begin
    rdata_o = '0;
    if (mode_hit) rdata_o = 32'(mode_q);
    for (int i = 0; i < N_CH; i++)
      if (ch_hit && ch_idx == CH_IDX_W'(i)) rdata_o = chan_rdata[i];
  end

  p_door_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(doorbell_o));
  p_mode_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && mode_hit) |=> $stable(mode_o));
endmodule

// File: tb/tb_dma_chan_regfile.sv
module tb_dma_chan_regfile;
  localparam int N_CH = 30;
  localparam int NV   = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [13:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [N_CH*4-1:0]  state = '0;
  logic [N_CH*13-1:0] evt = '0;
  logic [N_CH-1:0]   q_en, q_pause, q_reset, doorbell, irq;
  logic              mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_chan_regfile dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .state_i(state), .evt_i(evt), .q_en_o(q_en), .q_pause_o(q_pause),
    .q_reset_o(q_reset), .doorbell_o(doorbell), .irq_o(irq), .mode_o(mode)
  );

  // {address, write data, expected read}
  localparam logic [77:0] VECS [NV] = '{
    {14'h0000, 32'hDEADBEEF, 32'hDEADBEEF},  // R1
    {14'h0004, 32'h12345678, 32'h12345678},  // R1
    {14'h0108, 32'hABCD1234, 32'h00001234},  // R1
    {14'h050C, 32'h000003FF, 32'h000003FF},  // R1
    {14'h1D10, 32'hCAFEF00D, 32'hCAFEF00D},  // R1 last channel
    {14'h1D14, 32'h0BADF00D, 32'h0BADF00D},  // R1
    {14'h0218, 32'hFFFFFFFF, 32'h0000FFFF},  // R1
    {14'h031C, 32'h00000077, 32'h00000077},  // R1
    {14'h0420, 32'hFFFFFFFF, 32'h00000011},  // R2
    {14'h0628, 32'hFFFFFFFF, 32'h00000000},  // R9 gap
    {14'h0744, 32'hFFFF0000, 32'h00000000},  // R7 mask width
    {14'h1E00, 32'h00000001, 32'h00000000},  // R9 channel out of range
    {14'h217C, 32'hFFFFFFFF, 32'h00000001},  // R8
    {14'h0002, 32'h000000FF, 32'h00000000}   // R9 misaligned
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // returns at the negedge following the capturing edge
  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(14'h0000, v); chk("R10 base", v, 32'h0);
    rd(14'h0044, v); chk("R10 mask", v, 32'h1FFF);
    chk("R10 outputs", {irq, doorbell, q_reset, q_en}, '0);
    chk("R10 mode", {31'b0, mode}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i][77:64], VECS[i][63:32]);
      rd(VECS[i][77:64], v);
      chk("R1/R2/R7/R8/R9 table", v, VECS[i][31:0]);
    end
    rd(14'h0000, v); chk("R9 misaligned write kept ch0", v, 32'hDEADBEEF);
    chk("R8 mode_o", {31'b0, mode}, 32'h1);
    chk("R2 enable/pause", {30'b0, q_pause[4], q_en[4]}, 32'h3);

    // R4 doorbell
    wr(14'h090C, 32'h5);
    chk("R4 doorbell pulse", 32'(doorbell), 32'(1 << 9));
    @(negedge clk);
    chk("R4 doorbell end", 32'(doorbell), 32'h0);

    // R3 queue reset on ch5 (tail 0x3FF from table)
    wr(14'h0524, 32'h1);
    chk("R3 strobe", 32'(q_reset), 32'(1 << 5));
    rd(14'h0524, v); chk("R3 ctrl1 reads 1", v, 32'h1);
    @(negedge clk);
    chk("R3 strobe end", 32'(q_reset), 32'h0);
    rd(14'h0524, v); chk("R3 ctrl1 clears", v, 32'h0);
    rd(14'h050C, v); chk("R3 tail zeroed", v, 32'h0);

    // R5 state readback, write ignored
    state[3*4 +: 4] = 4'hA;
    rd(14'h0330, v); chk("R5 state", v, 32'hA);
    wr(14'h0330, 32'h5);
    rd(14'h0330, v); chk("R5 write ignored", v, 32'hA);

    // R6/R7 on ch2
    wr(14'h0244, 32'h0);
    @(negedge clk); evt[2*13 +: 13] = 13'h0005;
    @(negedge clk); evt = '0;
    rd(14'h0240, v); chk("R6 set by event", v, 32'h5);
    chk("R7 irq unmasked", {31'b0, irq[2]}, 32'h1);
    wr(14'h0240, 32'h1);
    rd(14'h0240, v); chk("R6 w1c", v, 32'h4);
    @(negedge clk);
    wr_en = 1'b1; addr = 14'h0240; wdata = 32'h4; evt[2*13 +: 13] = 13'h0004;
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
    rd(14'h0240, v); chk("R6 set wins", v, 32'h4);
    wr(14'h0240, 32'h4);
    rd(14'h0240, v); chk("R6 cleared", v, 32'h0);
    chk("R7 irq drops", {31'b0, irq[2]}, 32'h0);

    // R7 mask gating on ch8 (reset mask all ones)
    @(negedge clk); evt[8*13 +: 13] = 13'h0001;
    @(negedge clk); evt = '0;
    rd(14'h0840, v); chk("R7 status latched", v, 32'h1);
    chk("R7 masked irq low", {31'b0, irq[8]}, 32'h0);
    wr(14'h0844, 32'h0);
    chk("R7 unmask raises", {31'b0, irq[8]}, 32'h1);
    wr(14'h0844, 32'h1FFF);
    chk("R7 remask lowers", {31'b0, irq[8]}, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule